// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the targets of subroutine returns in a speculative fetch pipeline. When fetch sees a call, it pushes the return address. When it sees a return, it pops. The predicted target is always available at the top output. The storage is a ring of `DEPTH` address registers. The top-of-stack pointer moves around this ring, so a deep call chain overwrites the oldest entries instead of stalling or raising an error.

The current top-of-stack index is visible at a port. Fetch can record that index next to each predicted branch. When a branch turns out to be mispredicted, the recovery logic drives the restore port with the recorded index and the corrected target. The stack jumps its pointer back to that index and writes the target there in a single cycle. A count of live entries is kept beside the pointer. It saturates at both ends and is reported on its own output.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous active-high reset sets the top index to 0, the occupancy to 0 and every stored entry to address 0.
- R2: A push advances the top index by one, wrapping from `DEPTH-1` to 0. It then stores the pushed address at the new index, so the address appears on the top output in the cycle after the push.
- R3: A pop moves the top index back by one, wrapping from 0 to `DEPTH-1`, and writes nothing. The top output then shows the entry already stored at the new index.
- R4: Occupancy rises by one on each push, up to a ceiling of `DEPTH`, and falls by one on each pop, down to a floor of 0.
- R5: When more than `DEPTH` addresses are pushed, the oldest entries are overwritten. The pointer keeps wrapping and the occupancy stays at `DEPTH`.
- R6: A pop while the occupancy is 0 still moves the index back with wraparound, leaves the occupancy at 0 and changes no entry.
- R7: A restore loads the top index with the supplied index and writes the supplied target into that entry. Occupancy is left unchanged.
- R8: A restore takes priority over a push or pop in the same cycle. The pushed address is not stored, and the pointer and occupancy follow the restore alone.
- R9: A push and a pop in the same cycle, without a restore, leave the index and occupancy unchanged and replace the current top entry with the pushed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe for a call |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Pop strobe for a return |
| restore_i | input | 1 | Misprediction recovery strobe |
| restore_idx_i | input | IW | Top index to restore |
| restore_addr_i | input | AW | Corrected target written at the restored index |
| top_addr_o | output | AW | Address stored at the current top index |
| top_idx_o | output | IW | Current top-of-stack index |
| occupancy_o | output | CW | Number of live entries, 0 to DEPTH |

## Verification
The bench goes after the two wrap points of the pointer. A design that compared against the wrong limit would step to an index past the ring or stall at the end instead of wrapping. It pushes past capacity and then pops everything back. This catches an occupancy that wraps to zero instead of saturating, or a pop that reads a stale slot instead of the overwritten one. A pop on an empty stack is checked for a count that underflows to its maximum. Same-cycle strobe combinations are checked for a push that leaks through a restore, and for a push-with-pop that moves the pointer or writes the slot above the top.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Single operation selected for a cycle after priority resolution
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_SWAP    = 3'd3,
    OP_RESTORE = 3'd4
  } ras_op_e;

endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
  import ras_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    restore_i,
  output ras_op_e op_o
);

  // Restore first, then the combined push/pop, then singles
  always_comb begin
    if (restore_i)            op_o = OP_RESTORE;
    else if (push_i && pop_i) op_o = OP_SWAP;
    else if (push_i)          op_o = OP_PUSH;
    else if (pop_i)           op_o = OP_POP;
    else                      op_o = OP_IDLE;
  end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  ras_op_e       op_i,
  input  logic [IW-1:0] restore_idx_i,
  output logic [IW-1:0] tos_q,
  output logic [IW-1:0] tos_up,
  output logic [CW-1:0] cnt_q,
  output logic          ev_wrap_up,
  output logic          ev_wrap_dn,
  output logic          ev_overflow,
  output logic          ev_underflow
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [IW-1:0] ring_inc(input logic [IW-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IW-1:0] ring_dec(input logic [IW-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_up(input logic [CW-1:0] c);
    return (c >= FULL_CNT) ? FULL_CNT : c + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_down(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  logic [IW-1:0] tos_d;
  logic [CW-1:0] cnt_d;

  assign tos_up       = ring_inc(tos_q);
  assign ev_wrap_up   = (op_i == OP_PUSH) && (tos_q == LAST_IDX);
  assign ev_wrap_dn   = (op_i == OP_POP)  && (tos_q == '0);
  assign ev_overflow  = (op_i == OP_PUSH) && (cnt_q == FULL_CNT);
  assign ev_underflow = (op_i == OP_POP)  && (cnt_q == '0);

  always_comb begin
    tos_d = tos_q;
    cnt_d = cnt_q;
    unique case (op_i)
      OP_PUSH: begin
        tos_d = tos_up;
        cnt_d = cnt_up(cnt_q);
      end
      OP_POP: begin
        tos_d = ring_dec(tos_q);
        cnt_d = cnt_down(cnt_q);
      end
      OP_RESTORE: tos_d = restore_idx_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else begin
      tos_q <= tos_d;
      cnt_q <= cnt_d;
    end
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_PUSH |=> tos_q == (($past(tos_q) == LAST_IDX) ? '0 : $past(tos_q) + 1'b1)); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_POP |=> tos_q == (($past(tos_q) == '0) ? LAST_IDX : $past(tos_q) - 1'b1)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT); // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_overflow |=> cnt_q == FULL_CNT); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    ev_underflow |=> cnt_q == '0); // R6
  AST_RESTORE_CNT: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_RESTORE |=> $stable(cnt_q)); // R7
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_SWAP |=> $stable(tos_q) && $stable(cnt_q)); // R9

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          hit;
    logic [AW-1:0] q;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (hit) q <= wr_data;
    end
    assign slot[g] = q;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < DEPTH) rd_data = slot[rd_idx];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> slot[$past(wr_idx)] == $past(wr_data)); // R2

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  input  logic          restore_i,
  input  logic [IW-1:0] restore_idx_i,
  input  logic [AW-1:0] restore_addr_i,
  output logic [AW-1:0] top_addr_o,
  output logic [IW-1:0] top_idx_o,
  output logic [CW-1:0] occupancy_o
);

  ras_op_e       op;
  logic [IW-1:0] tos_q;
  logic [IW-1:0] tos_up;
  logic [CW-1:0] cnt_q;
  logic          ev_wrap_up, ev_wrap_dn, ev_overflow, ev_underflow;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_data;

  ras_op_decode u_dec (
    .push_i    (push_i),
    .pop_i     (pop_i),
    .restore_i (restore_i),
    .op_o      (op)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk           (clk),
    .rst           (rst),
    .op_i          (op),
    .restore_idx_i (restore_idx_i),
    .tos_q         (tos_q),
    .tos_up        (tos_up),
    .cnt_q         (cnt_q),
    .ev_wrap_up    (ev_wrap_up),
    .ev_wrap_dn    (ev_wrap_dn),
    .ev_overflow   (ev_overflow),
    .ev_underflow  (ev_underflow)
  );

  // Write routing: push lands one slot above, swap on the top, restore at the given slot
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = tos_q;
    wr_data = push_addr_i;
    unique case (op)
      OP_PUSH: begin
        wr_en  = 1'b1;
        wr_idx = tos_up;
      end
      OP_SWAP: wr_en = 1'b1;
      OP_RESTORE: begin
        wr_en   = 1'b1;
        wr_idx  = restore_idx_i;
        wr_data = restore_addr_i;
      end
      default: ;
    endcase
  end

  ras_entry_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (tos_q),
    .rd_data (top_addr_o)
  );

  assign top_idx_o   = tos_q;
  assign occupancy_o = cnt_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> top_idx_o == '0 && occupancy_o == '0 && top_addr_o == '0); // R1
  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    push_i && !pop_i && !restore_i |=> top_addr_o == $past(push_addr_i)); // R2
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> top_idx_o == $past(restore_idx_i) && top_addr_o == $past(restore_addr_i)); // R7
  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (rst)
    restore_i && (push_i || pop_i) |=> top_addr_o == $past(restore_addr_i)); // R8
  AST_SWAP_WRITE: assert property (@(posedge clk) disable iff (rst)
    push_i && pop_i && !restore_i |=> top_addr_o == $past(push_addr_i)); // R9

endmodule

// File: tb/ret_addr_stack_tb_top.sv
`timescale 1ns/1ps
module ret_addr_stack_tb_top;

  localparam int D  = 8;
  localparam int AW = 32;
  localparam int IW = $clog2(D);
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          push_i, pop_i, restore_i;
  logic [AW-1:0] push_addr_i, restore_addr_i;
  logic [IW-1:0] restore_idx_i;
  logic [AW-1:0] top_addr_o;
  logic [IW-1:0] top_idx_o;
  logic [CW-1:0] occupancy_o;

  int checks   = 0;
  int failures = 0;
  logic [AW-1:0] m_mem [D];
  int m_tos, m_cnt;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.DEPTH(D), .AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i),
    .restore_i(restore_i), .restore_idx_i(restore_idx_i), .restore_addr_i(restore_addr_i),
    .top_addr_o(top_addr_o), .top_idx_o(top_idx_o), .occupancy_o(occupancy_o)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, "top_idx", top_idx_o, m_tos);
    check(tag, "occupancy", occupancy_o, m_cnt);
    check(tag, "top_addr", top_addr_o, m_mem[m_tos]);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; push_i = 0; pop_i = 0; restore_i = 0;
    push_addr_i = '0; restore_addr_i = '0; restore_idx_i = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_tos = 0; m_cnt = 0;
    for (int i = 0; i < D; i++) m_mem[i] = '0;
  endtask

  // One cycle of stimulus, reference update from the requirements, then compare
  task automatic do_op(input bit ps, input bit pp, input bit rs, input logic [AW-1:0] pa,
                       input int ri, input logic [AW-1:0] ra, input string tag);
    @(negedge clk);
    push_i = ps; pop_i = pp; restore_i = rs;
    push_addr_i = pa; restore_idx_i = IW'(ri); restore_addr_i = ra;
    @(negedge clk);
    push_i = 0; pop_i = 0; restore_i = 0;
    if (rs) begin
      m_tos = ri; m_mem[m_tos] = ra;
    end else if (ps && pp) begin
      m_mem[m_tos] = pa;
    end else if (ps) begin
      m_tos = (m_tos + 1) % D; m_mem[m_tos] = pa;
      if (m_cnt < D) m_cnt++;
    end else if (pp) begin
      m_tos = (m_tos + D - 1) % D;
      if (m_cnt > 0) m_cnt--;
    end
    check_state(tag);
  endtask

  task automatic t_reset();
    do_op(1, 0, 0, 32'hDEAD_0001, 0, 0, "R2");
    apply_reset();
    check_state("R1");
    check("R1", "reset idx literal", top_idx_o, 0);
  endtask

  task automatic t_pop_empty();
    apply_reset();
    do_op(0, 1, 0, 0, 0, 0, "R6");
    check("R6", "wrap idx", top_idx_o, D - 1);
    check("R6", "count floor", occupancy_o, 0);
    do_op(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < D; i++) do_op(0, 1, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_push_overflow();
    apply_reset();
    for (int i = 0; i < D; i++) do_op(1, 0, 0, 32'h1000_0000 + i, 0, 0, "R2");
    check("R2", "wrap to zero", top_idx_o, 0);
    check("R4", "count at ceiling", occupancy_o, D);
    for (int i = 0; i < 3; i++) do_op(1, 0, 0, 32'h2000_0000 + i, 0, 0, "R5");
    check("R5", "count saturated", occupancy_o, D);
    for (int i = 0; i < D; i++) do_op(0, 1, 0, 0, 0, 0, "R5");
    check("R4", "count drained", occupancy_o, 0);
    do_op(0, 1, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_restore();
    do_op(0, 0, 1, 0, 5, 32'hCAFE_0005, "R7");
    do_op(0, 1, 0, 0, 0, 0, "R3");
    do_op(0, 0, 1, 0, D - 1, 32'hCAFE_0007, "R7");
    do_op(1, 0, 0, 32'h3000_0000, 0, 0, "R2");
  endtask

  task automatic t_priority();
    do_op(1, 0, 1, 32'hBAD0_0001, 2, 32'hABCD_0002, "R8");
    do_op(0, 1, 1, 0, 6, 32'hABCD_0006, "R8");
    do_op(1, 1, 1, 32'hBAD0_0003, 3, 32'hABCD_0003, "R8");
    do_op(0, 1, 0, 0, 0, 0, "R8");
    check("R8", "pushed addr not stored above", top_addr_o, m_mem[2]);
  endtask

  task automatic t_swap();
    apply_reset();
    do_op(1, 0, 0, 32'h4000_0001, 0, 0, "R2");
    do_op(1, 0, 0, 32'h4000_0002, 0, 0, "R2");
    do_op(1, 1, 0, 32'h5555_0000, 0, 0, "R9");
    check("R9", "idx held", top_idx_o, 2);
    check("R9", "count held", occupancy_o, 2);
    do_op(0, 1, 0, 0, 0, 0, "R9");
    check("R9", "lower entry untouched", top_addr_o, 32'h4000_0001);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    apply_reset();
    t_reset();
    t_pop_empty();
    t_push_overflow();
    t_restore();
    t_priority();
    t_swap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule